// File: doc/BRIEF.md
# Banked Interrupt Controller with Normal and Fast Request Classes

This block collects up to 48 level-sensitive interrupt inputs, grouped into three banks of sixteen, and turns them into two request lines for a processor: a normal request and a fast request. Software reaches it over a small 16-bit register bus with a write strobe, an address, write data and registered read data. For each source, software chooses whether the source is enabled and which of the two classes it belongs to. Each class keeps its own latched pending flags, and software clears them by writing ones.

Besides the two request lines, the controller presents an entry address for the normal class. The address is a programmable 32-bit base plus four bytes for each step of the index of the lowest-numbered source that is pending and enabled. A handler can use it to jump straight to the right table slot. A mode bit selects whether disabled sources may latch and show up in the pending registers.

Register map (6-bit word address, bank index b = 0..2): enable bank b at 0x00+b, class select bank b at 0x04+b, normal pending bank b at 0x08+b, fast pending bank b at 0x0C+b, mode at 0x10 (bit 0), base low half at 0x11, base high half at 0x12, entry address low half at 0x13, entry address high half at 0x14.

Top module: `intc_banked`

## Requirements
- R1: After reset, every enable, class select, pending, mode and base register reads 0, both request outputs are low and the entry address is 0.
- R2: Source n is controlled by bit (n mod 16) of the bank-(n div 16) registers. Writing an enable register and reading it back returns the written value.
- R3: With mode bit 0 clear, a source whose enable bit is 0 never latches as pending and never raises a request output.
- R4: A source with its class-select bit set latches into the fast pending register and drives the fast request. With the bit clear, it latches into the normal pending register and drives the normal request.
- R5: Writing a 1 to a pending bit clears it. Writing a 0 leaves it unchanged. Writing 0xFFFF clears the whole bank.
- R6: If a source is high in the same cycle that its pending bit is written with 1, the bit stays set.
- R7: With mode bit 0 set, a disabled source latches and shows in its pending register, yet it does not raise a request output.
- R8: If a source is masked and its pending bit is then cleared while its input is still high, it stays not pending, and re-enabling it after the input falls raises no request.
- R9: Each request output is high exactly when some pending bit of its class has its enable bit set, and it stays high until a register write.
- R10: The entry address equals the base plus 4 times the index of the lowest-numbered pending, enabled normal-class source. When there is none, it equals the base.
- R11: A read returns the addressed register on the clock edge after the address is presented. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src | input | 48 | Level-sensitive interrupt inputs |
| wr_en | input | 1 | Register write strobe |
| addr | input | 6 | Register word address |
| wdata | input | 16 | Register write data |
| rdata | output | 16 | Registered read data |
| irq_out | output | 1 | Normal-class request |
| fiq_out | output | 1 | Fast-class request |
| entry_addr | output | 32 | Base plus stride times lowest pending normal source |

## Verification
A level on a source input and a software write-one-to-clear of the same pending bit can land in the same clock cycle. The bench provokes this by holding a source high while it writes the clearing one, and then expects the bit to read back still set. It also places a masking write just before a clearing write with the input still high, and expects the source to read back not pending and to stay quiet once it is re-enabled. The read-back values go into a scoreboard queue stamped with their due cycle, and they are compared when the registered read data appears.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int BANK_W  = 16;
  localparam int ADDR_W  = 6;
  localparam int ENTRY_W = 2 * BANK_W;

  localparam logic [ADDR_W-1:0] A_EN   = 6'h00;
  localparam logic [ADDR_W-1:0] A_SEL  = 6'h04;
  localparam logic [ADDR_W-1:0] A_IPND = 6'h08;
  localparam logic [ADDR_W-1:0] A_FPND = 6'h0C;
  localparam logic [ADDR_W-1:0] A_RAW  = 6'h10;
  localparam logic [ADDR_W-1:0] A_BLO  = 6'h11;
  localparam logic [ADDR_W-1:0] A_BHI  = 6'h12;
  localparam logic [ADDR_W-1:0] A_ELO  = 6'h13;
  localparam logic [ADDR_W-1:0] A_EHI  = 6'h14;
endpackage

// File: rtl/intc_rst_sync.sv
module intc_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign srst_n = s2_q;
endmodule

// File: rtl/intc_bank.sv
module intc_bank #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] src,
  input  logic         raw,
  input  logic         en_we,
  input  logic         sel_we,
  input  logic         iclr_we,
  input  logic         fclr_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] en_q,
  output logic [W-1:0] sel_q,
  output logic [W-1:0] ipend_q,
  output logic [W-1:0] fpend_q
);
  logic [W-1:0] en_d, sel_d, ipend_d, fpend_d;
  logic [W-1:0] gate, iclr, fclr;

  always_comb begin
    en_d    = en_we  ? wdata : en_q;
    sel_d   = sel_we ? wdata : sel_q;
    gate    = en_q | {W{raw}};
    iclr    = iclr_we ? wdata : '0;
    fclr    = fclr_we ? wdata : '0;
    // a set in the same cycle outweighs a clear
    ipend_d = (ipend_q & ~iclr) | (src & ~sel_q & gate);
    fpend_d = (fpend_q & ~fclr) | (src &  sel_q & gate);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      sel_q   <= '0;
      ipend_q <= '0;
      fpend_q <= '0;
    end else begin
      en_q    <= en_d;
      sel_q   <= sel_d;
      ipend_q <= ipend_d;
      fpend_q <= fpend_d;
    end
  end
endmodule

// File: rtl/intc_prio.sv
module intc_prio #(
  parameter int N           = 48,
  parameter int OUT_W       = 32,
  parameter int STRIDE_LOG2 = 2
) (
  input  logic [N-1:0]     req,
  input  logic [OUT_W-1:0] base,
  output logic [OUT_W-1:0] entry
);
  localparam int IDXW = (N > 1) ? $clog2(N) : 1;

  logic [IDXW-1:0] idx;

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IDXW'(i);
    end
    entry = base + (OUT_W'(idx) << STRIDE_LOG2);
  end
endmodule

// File: rtl/intc_banked.sv
module intc_banked
  import intc_pkg::*;
#(
  parameter int N_BANKS     = 3,
  parameter int STRIDE_LOG2 = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [N_BANKS*BANK_W-1:0]   src,
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [BANK_W-1:0]           wdata,
  output logic [BANK_W-1:0]           rdata,
  output logic                        irq_out,
  output logic                        fiq_out,
  output logic [ENTRY_W-1:0]          entry_addr
);
  localparam int NSRC = N_BANKS * BANK_W;

  logic                rst_sync_n;
  logic [BANK_W-1:0]   en_b    [N_BANKS];
  logic [BANK_W-1:0]   sel_b   [N_BANKS];
  logic [BANK_W-1:0]   ipend_b [N_BANKS];
  logic [BANK_W-1:0]   fpend_b [N_BANKS];
  logic [NSRC-1:0]     en_all, sel_all, ipend_all, fpend_all;
  logic                raw_q, raw_d;
  logic [BANK_W-1:0]   blo_q, blo_d, bhi_q, bhi_d;
  logic [BANK_W-1:0]   rdata_q, rdata_d;
  logic [ENTRY_W-1:0]  base;

  intc_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
    intc_bank #(.W(BANK_W)) u_bank (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .src     (src[b*BANK_W +: BANK_W]),
      .raw     (raw_q),
      .en_we   (wr_en && (addr == A_EN   + ADDR_W'(b))),
      .sel_we  (wr_en && (addr == A_SEL  + ADDR_W'(b))),
      .iclr_we (wr_en && (addr == A_IPND + ADDR_W'(b))),
      .fclr_we (wr_en && (addr == A_FPND + ADDR_W'(b))),
      .wdata   (wdata),
      .en_q    (en_b[b]),
      .sel_q   (sel_b[b]),
      .ipend_q (ipend_b[b]),
      .fpend_q (fpend_b[b])
    );
    assign en_all   [b*BANK_W +: BANK_W] = en_b[b];
    assign sel_all  [b*BANK_W +: BANK_W] = sel_b[b];
    assign ipend_all[b*BANK_W +: BANK_W] = ipend_b[b];
    assign fpend_all[b*BANK_W +: BANK_W] = fpend_b[b];
  end

  assign base = {bhi_q, blo_q};

  intc_prio #(.N(NSRC), .OUT_W(ENTRY_W), .STRIDE_LOG2(STRIDE_LOG2)) u_prio (
    .req   (ipend_all & en_all),
    .base  (base),
    .entry (entry_addr)
  );

  assign irq_out = |(ipend_all & en_all);
  assign fiq_out = |(fpend_all & en_all);

  always_comb begin
    raw_d = (wr_en && addr == A_RAW) ? wdata[0] : raw_q;
    blo_d = (wr_en && addr == A_BLO) ? wdata    : blo_q;
    bhi_d = (wr_en && addr == A_BHI) ? wdata    : bhi_q;

    rdata_d = '0;
    for (int b = 0; b < N_BANKS; b++) begin
      if (addr == A_EN   + ADDR_W'(b)) rdata_d = en_b[b];
      if (addr == A_SEL  + ADDR_W'(b)) rdata_d = sel_b[b];
      if (addr == A_IPND + ADDR_W'(b)) rdata_d = ipend_b[b] & (en_b[b] | {BANK_W{raw_q}});
      if (addr == A_FPND + ADDR_W'(b)) rdata_d = fpend_b[b] & (en_b[b] | {BANK_W{raw_q}});
    end
    case (addr)
      A_RAW:   rdata_d = {{(BANK_W-1){1'b0}}, raw_q};
      A_BLO:   rdata_d = blo_q;
      A_BHI:   rdata_d = bhi_q;
      A_ELO:   rdata_d = entry_addr[BANK_W-1:0];
      A_EHI:   rdata_d = entry_addr[ENTRY_W-1:BANK_W];
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      raw_q   <= 1'b0;
      blo_q   <= '0;
      bhi_q   <= '0;
      rdata_q <= '0;
    end else begin
      raw_q   <= raw_d;
      blo_q   <= blo_d;
      bhi_q   <= bhi_d;
      rdata_q <= rdata_d;
    end
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/intc_banked_chk.sv
module intc_banked_chk #(
  parameter int NSRC  = 48,
  parameter int AW    = 6,
  parameter int DW    = 16,
  parameter int EW    = 32,
  parameter logic [AW-1:0] LAST_ADDR = 6'h14
) (
  input logic            clk,
  input logic            rst_s,
  input logic [NSRC-1:0] src,
  input logic            wr_en,
  input logic [AW-1:0]   addr,
  input logic [DW-1:0]   rdata,
  input logic            irq_out,
  input logic            fiq_out,
  input logic [EW-1:0]   entry_addr,
  input logic            raw_q,
  input logic [NSRC-1:0] en_all,
  input logic [NSRC-1:0] sel_all,
  input logic [NSRC-1:0] ipend_all,
  input logic [NSRC-1:0] fpend_all,
  input logic [EW-1:0]   base
);
  logic [NSRC-1:0] iset_c, fset_c;
  assign iset_c = src & ~sel_all & (en_all | {NSRC{raw_q}});
  assign fset_c = src &  sel_all & (en_all | {NSRC{raw_q}});

  p_masked_no_latch_r3: assert property (@(posedge clk) disable iff (!rst_s)
    !raw_q |=> ((ipend_all & ~$past(ipend_all) & ~$past(en_all)) == '0));

  p_irq_set_r4: assert property (@(posedge clk) disable iff (!rst_s)
    (iset_c != '0) |=> ((ipend_all & $past(iset_c)) == $past(iset_c)));

  p_fiq_set_r4: assert property (@(posedge clk) disable iff (!rst_s)
    (fset_c != '0) |=> ((fpend_all & $past(fset_c)) == $past(fset_c)));

  p_irq_hold_r9: assert property (@(posedge clk) disable iff (!rst_s)
    (irq_out && !wr_en) |=> irq_out);

  p_fiq_hold_r9: assert property (@(posedge clk) disable iff (!rst_s)
    (fiq_out && !wr_en) |=> fiq_out);

  p_entry_base_r10: assert property (@(posedge clk) disable iff (!rst_s)
    !irq_out |-> (entry_addr == base));

  p_unmapped_zero_r11: assert property (@(posedge clk) disable iff (!rst_s)
    (addr > LAST_ADDR) |=> (rdata == '0));
endmodule

bind intc_banked intc_banked_chk #(
  .NSRC(NSRC), .AW(intc_pkg::ADDR_W), .DW(intc_pkg::BANK_W),
  .EW(intc_pkg::ENTRY_W), .LAST_ADDR(intc_pkg::A_EHI)
) u_chk (
  .clk        (clk),
  .rst_s      (rst_sync_n),
  .src        (src),
  .wr_en      (wr_en),
  .addr       (addr),
  .rdata      (rdata),
  .irq_out    (irq_out),
  .fiq_out    (fiq_out),
  .entry_addr (entry_addr),
  .raw_q      (raw_q),
  .en_all     (en_all),
  .sel_all    (sel_all),
  .ipend_all  (ipend_all),
  .fpend_all  (fpend_all),
  .base       (base)
);

// File: tb/intc_banked_bench.sv
module intc_banked_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [47:0] src = '0;
  logic        wr_en = 1'b0;
  logic [5:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq_out, fiq_out;
  logic [31:0] entry_addr;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  typedef struct {
    int          due;
    logic [15:0] exp;
    string       tag;
  } rd_item_t;
  rd_item_t sb[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  intc_banked u_intc_banked (
    .clk(clk), .rst_n(rst_n), .src(src), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq_out(irq_out), .fiq_out(fiq_out),
    .entry_addr(entry_addr)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // monitor: compare registered read data when each item falls due
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due == cyc) begin
      check(sb[0].tag, {16'h0, rdata}, {16'h0, sb[0].exp});
      void'(sb.pop_front());
    end
  end

  task automatic step();
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr(logic [5:0] a, logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
  endtask

  task automatic rd(logic [5:0] a, logic [15:0] exp, string tag);
    rd_item_t it;
    @(negedge clk);
    wr_en = 1'b0; addr = a;
    it.due = cyc + 1; it.exp = exp; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic pulse(int n);
    @(negedge clk);
    wr_en = 1'b0; src[n] = 1'b1;
    @(negedge clk);
    src[n] = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) step();

    // R1 reset state
    check("R1 irq_out", {31'h0, irq_out}, 0);
    check("R1 fiq_out", {31'h0, fiq_out}, 0);
    check("R1 entry", entry_addr, 0);
    rd(6'h00, 16'h0000, "R1 enable0");
    rd(6'h06, 16'h0000, "R1 select2");
    rd(6'h09, 16'h0000, "R1 ipend1");
    rd(6'h11, 16'h0000, "R1 base_lo");
    rd(6'h10, 16'h0000, "R1 mode");

    // R2 bank mapping: source 35 is bank 2 bit 3
    wr(6'h02, 16'h0008);
    rd(6'h02, 16'h0008, "R2 enable2 readback");
    pulse(35);
    step();
    check("R9 irq_out after src35", {31'h0, irq_out}, 1);
    rd(6'h0A, 16'h0008, "R2 ipend2 bit3");
    check("R10 entry src35 base0", entry_addr, 32'd140);

    // R10 with base
    wr(6'h11, 16'h1000);
    wr(6'h12, 16'h0002);
    step();
    check("R10 entry src35", entry_addr, 32'h0002_108C);
    rd(6'h13, 16'h108C, "R11 entry low");
    rd(6'h14, 16'h0002, "R11 entry high");

    // R10 lowest index wins
    wr(6'h00, 16'h0020);
    pulse(5);
    step();
    check("R10 entry lowest src5", entry_addr, 32'h0002_1014);

    // R5 write-one-to-clear
    wr(6'h0A, 16'h0008);
    wr(6'h08, 16'h0000);
    rd(6'h08, 16'h0020, "R5 zero write keeps");
    rd(6'h0A, 16'h0000, "R5 one write clears");
    wr(6'h08, 16'hFFFF);
    step();
    check("R5 irq_out after full clear", {31'h0, irq_out}, 0);
    check("R10 entry base alone", entry_addr, 32'h0002_1000);

    // R4 fast routing: source 16 = bank1 bit0
    wr(6'h05, 16'h0001);
    wr(6'h01, 16'h0001);
    pulse(16);
    step();
    check("R4 fiq_out", {31'h0, fiq_out}, 1);
    check("R4 irq_out stays low", {31'h0, irq_out}, 0);
    rd(6'h0D, 16'h0001, "R4 fpend1");
    rd(6'h09, 16'h0000, "R4 ipend1 empty");
    wr(6'h0D, 16'hFFFF);
    step();
    check("R9 fiq_out after clear", {31'h0, fiq_out}, 0);

    // R3 disabled source in masked mode (source 20 = bank1 bit4)
    pulse(20);
    step();
    rd(6'h09, 16'h0000, "R3 disabled not latched");
    check("R3 irq_out low", {31'h0, irq_out}, 0);

    // R7 raw mode
    wr(6'h10, 16'h0001);
    pulse(20);
    rd(6'h09, 16'h0010, "R7 raw shows disabled");
    step();
    check("R7 irq_out low", {31'h0, irq_out}, 0);
    wr(6'h09, 16'hFFFF);
    wr(6'h10, 16'h0000);

    // R6 set beats clear (source 6)
    wr(6'h00, 16'h0040);
    @(negedge clk);
    wr_en = 1'b0; src[6] = 1'b1;
    wr(6'h08, 16'h0040);
    rd(6'h08, 16'h0040, "R6 set wins over clear");

    // R8 mask then clear with input still high
    wr(6'h00, 16'h0000);
    wr(6'h08, 16'h0040);
    step();
    check("R8 irq_out low", {31'h0, irq_out}, 0);
    rd(6'h08, 16'h0000, "R8 not pending");
    rd(6'h00, 16'h0000, "R8 still disabled");
    @(negedge clk);
    wr_en = 1'b0; src[6] = 1'b0;
    wr(6'h00, 16'h0040);
    step();
    check("R8 no request on re-enable", {31'h0, irq_out}, 0);

    // R11 unmapped addresses
    wr(6'h3F, 16'hABCD);
    rd(6'h3F, 16'h0000, "R11 unmapped high");
    rd(6'h03, 16'h0000, "R11 missing bank");

    repeat (3) step();
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL R11: actual %0d reads outstanding expected 0", sb.size());
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule